// File: doc/BRIEF.md
# Calendar Clock Register and Update Core

This block keeps time of day and calendar date for a system that has no other clock source it can trust. The host reaches it through a two-step indexed port: it first loads an index byte, then reads the byte at that index or writes a new one. Ten byte-wide time fields are kept: seconds, minutes and hours, an alarm value for each of those three, day of week, day of month, month and year within the century. Two writable control bytes set the counting mode. Two status bytes are read-only. A general-purpose byte RAM follows them.

An external strobe marks each second. The core raises an update-in-progress flag at once and advances the calendar a fixed number of cycles later. It keeps the flag raised for a few more cycles, so a host that polls the flag and sees it clear always has a window in which the time fields are steady. The count runs in packed BCD or in plain binary, with a 24-hour or a 12-hour hour field. A set bit stops all updates while software loads a new time. Stored values are never converted when a mode bit changes.

Top module: `rtc_calendar_core`

## Requirements
- R1: A pulse on `idx_we` loads `wdata` into the index register. A pulse on `data_we` writes `wdata` to the byte selected by the index held before that edge. `rdata` always shows the byte at the held index. The index map is: 0 seconds, 1 alarm seconds, 2 minutes, 3 alarm minutes, 4 hours, 5 alarm hours, 6 day of week, 7 day of month, 8 month, 9 year, 10 control A, 11 control B, 12 status C, 13 status D. Alarm bytes are never changed by the advance.
- R2: With control B bit 2 clear, every field counts in packed BCD (tens in bits 7:4, units in bits 3:0). Seconds and minutes wrap from 0x59 to 0x00 and carry into the next field.
- R3: With control B bit 2 set, every field counts in plain binary, for example seconds 9 becomes 0x0A.
- R4: With control B bit 1 set, hours run 0 to 23 and the day carries at 23 to 0. With it clear, hours run 1 to 12 with bit 7 meaning PM. 11 AM becomes 12 PM (0x92 in BCD). 11 PM becomes 12 AM (0x12) and carries the day. 12 becomes 1 and keeps the PM bit.
- R5: Day of month wraps to 1 after the month's last day: 30 days for April, June, September and November; 29 for February when the year value is divisible by 4, else 28; 31 for the other months. Day of week wraps from 7 to 1 at midnight.
- R6: Month wraps from 12 to 1 and carries the year. Year wraps from 99 to 0.
- R7: While control B bit 7 is set, no advance takes place, the second strobe is ignored and the update flag stays 0.
- R8: Control A bit 7 is the read-only update flag. It reads 1 from the cycle after an accepted strobe, through the advance, until LEAD+HOLD+1 cycles have passed. Its other seven bits are plain storage.
- R9: Writing either mode bit of control B leaves every stored time and alarm byte unchanged.
- R10: Status C reads 0x00 and status D reads 0x80. Writes to either are ignored.
- R11: Indices 14 to 63 are 50 bytes of general RAM. Indices 64 to 255 read 0x00, and writes to them are ignored.
- R12: After reset the time is 00:00:00, day of week 1, date 1/1, year 0, control A 0x00, control B 0x02 (BCD, 24-hour, running), the index 0 and the RAM all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sec_pulse | input | 1 | One-cycle strobe, once per second |
| idx_we | input | 1 | Load `wdata` into the index register |
| data_we | input | 1 | Write `wdata` to the indexed byte |
| wdata | input | 8 | Host write data (index or byte) |
| rdata | output | 8 | Byte at the current index |

## Verification
A wrong carry or wrong limit in any field changes a time byte the cycle after the advance edge. The reference model in the bench compares the indexed byte on every cycle, so the error shows within one cycle whenever the index points at that field. Explicit checks also read every field after each rollover. A wrong update-timer state shows on control A bit 7, or as a time change outside the raised window, within the LEAD+HOLD+1 cycles that follow a strobe. A lost write, or a write that lands at the wrong index, shows at the next read of either affected byte.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
// Package rtc_cal_pkg
// Shared field encode/decode helpers and month-length rule for the
// calendar core. Assumes field values below 100 and a valid month.
package rtc_cal_pkg;

    localparam int BYTE_W = 8;

    // Turn a stored field into a plain number (BCD or binary storage).
    function automatic logic [6:0] field_dec(input logic [7:0] v, input logic bin);
        if (bin) return v[6:0];
        return 7'(v[7:4] * 10 + v[3:0]);
    endfunction

    // Turn a plain number into the stored representation.
    function automatic logic [7:0] field_enc(input logic [6:0] n, input logic bin);
        if (bin) return {1'b0, n};
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    // Last day of a month; a year divisible by four gives a long February.
    function automatic logic [6:0] month_days(input logic [6:0] mon, input logic [6:0] yr);
        case (mon)
            7'd2:                       return (yr[1:0] == 2'd0) ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:    return 7'd30;
            default:                    return 7'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_count_step.sv
`timescale 1ns/1ps
// Module rtc_count_step
// Combinational one-step advance of a single calendar field. When en is
// high the field moves up by one, or back to LO once it has reached top,
// and wrap reports that carry. When en is low the field passes through.
// Assumes the stored value is in range for the selected encoding.
module rtc_count_step
    import rtc_cal_pkg::*;
#(
    parameter logic [6:0] LO = 7'd0
) (
    input  logic [7:0] cur,
    input  logic [6:0] top,
    input  logic       bin,
    input  logic       en,
    output logic [7:0] nxt,
    output logic       wrap
);
    logic [6:0] num;

    // Decode, compare against the limit and re-encode the next value.
    always_comb begin
        num  = field_dec(cur, bin);
        wrap = en && (num >= top);
        if (!en)             nxt = cur;
        else if (num >= top) nxt = field_enc(LO, bin);
        else                 nxt = field_enc(num + 7'd1, bin);
    end
endmodule

// File: rtl/rtc_hour_step.sv
`timescale 1ns/1ps
// Module rtc_hour_step
// Combinational one-step advance of the hour field in 24-hour or 12-hour
// form. In 12-hour form bit 7 is the PM flag; 11 toggles it on the way to
// 12, and the day carries only when 11 PM moves on to 12 AM.
// Assumes a valid stored hour for the selected mode.
module rtc_hour_step
    import rtc_cal_pkg::*;
(
    input  logic [7:0] cur,
    input  logic       bin,
    input  logic       h24,
    input  logic       en,
    output logic [7:0] nxt,
    output logic       carry
);
    logic [6:0] hr;
    logic       pm;
    logic [7:0] enc;

    // Choose the next hour and decide whether the day carries.
    always_comb begin
        hr    = field_dec({1'b0, cur[6:0]}, bin);
        pm    = cur[7];
        nxt   = cur;
        carry = 1'b0;
        enc   = 8'd0;
        if (en) begin
            if (h24) begin
                if (hr >= 7'd23) begin
                    nxt   = field_enc(7'd0, bin);
                    carry = 1'b1;
                end else begin
                    nxt = field_enc(hr + 7'd1, bin);
                end
            end else if (hr == 7'd11) begin
                enc   = field_enc(7'd12, bin);
                nxt   = {~pm, enc[6:0]};
                carry = pm;
            end else if (hr >= 7'd12) begin
                enc = field_enc(7'd1, bin);
                nxt = {pm, enc[6:0]};
            end else begin
                enc = field_enc(hr + 7'd1, bin);
                nxt = {pm, enc[6:0]};
            end
        end
    end
endmodule

// File: rtl/rtc_update_timer.sv
`timescale 1ns/1ps
// Module rtc_update_timer
// Opens the update window on an accepted second strobe. The window flag
// rises the next cycle, the advance strobe fires LEAD cycles after that,
// and the window stays open HOLD more cycles. Freeze drops the window at
// once and blocks the advance. Strobes seen inside a window are dropped.
module rtc_update_timer #(
    parameter int LEAD = 4,
    parameter int HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    input  logic freeze,
    output logic uip,
    output logic step
);
    localparam int LAST = LEAD + HOLD;
    localparam int CW   = $clog2(LAST + 1);

    logic          busy_q;
    logic [CW-1:0] cnt_q;

    // Window state: open on a strobe, count through, close at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (freeze) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == CW'(LAST)) busy_q <= 1'b0;
            else                    cnt_q  <= cnt_q + 1'b1;
        end else if (pulse) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end
    end

    assign uip  = busy_q;
    assign step = busy_q && !freeze && (cnt_q == CW'(LEAD));

    // R8: an accepted strobe opens the window on the next cycle.
    a_r8_pulse_opens_uip: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !freeze && !busy_q) |=> uip);

    // R7: the set bit closes the window by the following cycle.
    a_r7_set_drops_uip: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> !uip);
endmodule

// File: rtl/rtc_user_ram.sv
`timescale 1ns/1ps
// Module rtc_user_ram
// General-purpose byte store occupying indices BASE..BASE+DEPTH-1 of the
// host index space. Reads and writes outside that span miss: they return
// zero and change nothing. Cleared by reset.
module rtc_user_ram #(
    parameter int BASE  = 14,
    parameter int DEPTH = 50,
    parameter int IW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] idx,
    input  logic          we,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];
    logic       hit;
    logic [IW-1:0] rel;

    assign hit = (idx >= IW'(BASE)) && (idx < IW'(BASE + DEPTH));
    assign rel = idx - IW'(BASE);

    // One storage byte per slot, each with its own address match.
    for (genvar g = 0; g < DEPTH; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n)                          mem[g] <= 8'd0;
            else if (we && idx == IW'(BASE + g)) mem[g] <= wdata;
        end
    end

    // Read mux: the addressed byte on a hit, zero otherwise.
    always_comb begin
        rdata = 8'd0;
        for (int k = 0; k < DEPTH; k++)
            if (hit && rel == IW'(k)) rdata = mem[k];
    end
endmodule

// File: rtl/rtc_calendar_core.sv
`timescale 1ns/1ps
// Module rtc_calendar_core
// Time-of-day and calendar keeper behind an indexed byte port. Holds the
// time, alarm and control bytes, runs the once-per-second carry chain in
// one cycle inside the update window, and maps the user RAM behind the
// status bytes. Assumes sec_pulse is a one-cycle strobe and that software
// loads values valid for the selected modes; no conversion on mode change.
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int LEAD      = 4,
    parameter int HOLD      = 2,
    parameter int RAM_BASE  = 14,
    parameter int RAM_DEPTH = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_pulse,
    input  logic       idx_we,
    input  logic       data_we,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);
    localparam int NTIME = 10;
    localparam int IX_CA = 10;
    localparam int IX_CB = 11;
    localparam int IX_SC = 12;
    localparam int IX_SD = 13;
    localparam int IW    = BYTE_W;

    localparam int F_SEC = 0, F_MIN = 2, F_HR = 4, F_DOW = 6, F_DOM = 7, F_MON = 8, F_YR = 9;

    logic [IW-1:0] idx_q;
    logic [7:0]    t_q   [NTIME];
    logic [7:0]    adv   [NTIME];
    logic [6:0]    ctla_q;
    logic [7:0]    ctlb_q;

    logic bin, h24, uip, step;
    logic w_sec, w_min, c_hr, w_dow, w_dom, w_mon, w_yr;
    logic [6:0] dom_top;
    logic [7:0] ram_rd;

    assign bin = ctlb_q[2];
    assign h24 = ctlb_q[1];

    rtc_update_timer #(.LEAD(LEAD), .HOLD(HOLD)) u_timer (
        .clk(clk), .rst_n(rst_n), .pulse(sec_pulse), .freeze(ctlb_q[7]),
        .uip(uip), .step(step));

    // Carry chain: each field steps only when the one below it wraps.
    rtc_count_step #(.LO(7'd0)) u_sec (.cur(t_q[F_SEC]), .top(7'd59), .bin(bin),
        .en(step), .nxt(adv[F_SEC]), .wrap(w_sec));
    rtc_count_step #(.LO(7'd0)) u_min (.cur(t_q[F_MIN]), .top(7'd59), .bin(bin),
        .en(w_sec), .nxt(adv[F_MIN]), .wrap(w_min));
    rtc_hour_step u_hr (.cur(t_q[F_HR]), .bin(bin), .h24(h24), .en(w_min),
        .nxt(adv[F_HR]), .carry(c_hr));
    rtc_count_step #(.LO(7'd1)) u_dow (.cur(t_q[F_DOW]), .top(7'd7), .bin(bin),
        .en(c_hr), .nxt(adv[F_DOW]), .wrap(w_dow));

    assign dom_top = month_days(field_dec(t_q[F_MON], bin), field_dec(t_q[F_YR], bin));

    rtc_count_step #(.LO(7'd1)) u_dom (.cur(t_q[F_DOM]), .top(dom_top), .bin(bin),
        .en(c_hr), .nxt(adv[F_DOM]), .wrap(w_dom));
    rtc_count_step #(.LO(7'd1)) u_mon (.cur(t_q[F_MON]), .top(7'd12), .bin(bin),
        .en(w_dom), .nxt(adv[F_MON]), .wrap(w_mon));
    rtc_count_step #(.LO(7'd0)) u_yr  (.cur(t_q[F_YR]), .top(7'd99), .bin(bin),
        .en(w_mon), .nxt(adv[F_YR]), .wrap(w_yr));

    // Alarm bytes are storage only and never advance.
    assign adv[1] = t_q[1];
    assign adv[3] = t_q[3];
    assign adv[5] = t_q[5];

    // Time and alarm bytes: a host write wins, else take the advanced value.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NTIME; i++) begin
            if (!rst_n)                             t_q[i] <= (i >= F_DOW && i <= F_MON) ? 8'd1 : 8'd0;
            else if (data_we && idx_q == IW'(i))    t_q[i] <= wdata;
            else if (step)                          t_q[i] <= adv[i];
        end
    end

    // Control bytes and index register; bit 7 of control A is not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctla_q <= 7'd0;
            ctlb_q <= 8'h02;
            idx_q  <= '0;
        end else begin
            if (data_we && idx_q == IW'(IX_CA)) ctla_q <= wdata[6:0];
            if (data_we && idx_q == IW'(IX_CB)) ctlb_q <= wdata;
            if (idx_we)                         idx_q  <= wdata;
        end
    end

    rtc_user_ram #(.BASE(RAM_BASE), .DEPTH(RAM_DEPTH), .IW(IW)) u_ram (
        .clk(clk), .rst_n(rst_n), .idx(idx_q), .we(data_we), .wdata(wdata),
        .rdata(ram_rd));

    // Read mux over the whole index space.
    always_comb begin
        if (idx_q < IW'(NTIME))        rdata = t_q[idx_q[3:0]];
        else if (idx_q == IW'(IX_CA))  rdata = {uip, ctla_q};
        else if (idx_q == IW'(IX_CB))  rdata = ctlb_q;
        else if (idx_q == IW'(IX_SC))  rdata = 8'h00;
        else if (idx_q == IW'(IX_SD))  rdata = 8'h80;
        else                           rdata = ram_rd;
    end

    logic wr_sec;
    assign wr_sec = data_we && (idx_q == IW'(F_SEC));

    // R8: seconds only move without a host write while the window is open.
    a_r8_step_inside_uip: assert property (@(posedge clk) disable iff (!rst_n)
        ((t_q[F_SEC] != $past(t_q[F_SEC])) && !$past(wr_sec)) |-> $past(uip));

    // R7: with the set bit held, seconds stay put unless the host writes them.
    a_r7_set_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (ctlb_q[7] && $past(ctlb_q[7]) && !$past(wr_sec)) |-> (t_q[F_SEC] == $past(t_q[F_SEC])));

    // R1: alarm seconds change only through a host write.
    a_r1_alarm_static: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(data_we) |-> $stable(t_q[1]));
endmodule

// File: tb/test_rtc_calendar_core.sv
`timescale 1ns/1ps
// Bench for rtc_calendar_core: behavioural reference model compared on
// every cycle, plus directed checks with literal expected values.
module test_rtc_calendar_core;
    localparam int LEAD = 4;
    localparam int HOLD = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sec_pulse = 1'b0, idx_we = 1'b0, data_we = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rtc_calendar_core #(.LEAD(LEAD), .HOLD(HOLD)) i_rtc_calendar_core (
        .clk(clk), .rst_n(rst_n), .sec_pulse(sec_pulse), .idx_we(idx_we),
        .data_we(data_we), .wdata(wdata), .rdata(rdata));

    // ---------------- reference model ----------------
    int m_t [10];
    int m_ram [50];
    int m_a, m_b, m_idx, m_busy, m_cnt;

    function automatic int dec(int v);
        if (m_b[2]) return v;
        return (v >> 4) * 10 + (v & 15);
    endfunction

    function automatic int enc(int n);
        if (m_b[2]) return n;
        return (n / 10) * 16 + (n % 10);
    endfunction

    function automatic int days_in(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_advance();
        int s, mi, h, dw, dm, mo, yr, hh;
        s = dec(m_t[0]); mi = dec(m_t[2]);
        dw = dec(m_t[6]); dm = dec(m_t[7]); mo = dec(m_t[8]); yr = dec(m_t[9]);
        if (m_b[1]) h = dec(m_t[4]);
        else h = (dec(m_t[4] & 127) % 12) + (((m_t[4] & 128) != 0) ? 12 : 0);
        s++;
        if (s == 60) begin
            s = 0; mi++;
            if (mi == 60) begin
                mi = 0; h++;
                if (h == 24) begin
                    h = 0;
                    dw = (dw == 7) ? 1 : dw + 1;
                    dm++;
                    if (dm > days_in(mo, yr)) begin
                        dm = 1; mo++;
                        if (mo == 13) begin mo = 1; yr = (yr + 1) % 100; end
                    end
                end
            end
        end
        m_t[0] = enc(s); m_t[2] = enc(mi);
        m_t[6] = enc(dw); m_t[7] = enc(dm); m_t[8] = enc(mo); m_t[9] = enc(yr);
        if (m_b[1]) m_t[4] = enc(h);
        else begin
            hh = h % 12;
            if (hh == 0) hh = 12;
            m_t[4] = enc(hh) | ((h >= 12) ? 128 : 0);
        end
    endtask

    function automatic int m_read();
        if (m_idx < 10)  return m_t[m_idx];
        if (m_idx == 10) return (m_busy != 0 ? 128 : 0) | m_a;
        if (m_idx == 11) return m_b;
        if (m_idx == 12) return 0;
        if (m_idx == 13) return 128;
        if (m_idx < 64)  return m_ram[m_idx - 14];
        return 0;
    endfunction

    // Model state moves on the same edge as the design, from the same inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_t[i]) m_t[i] = (i >= 6 && i <= 8) ? 1 : 0;
            foreach (m_ram[i]) m_ram[i] = 0;
            m_a = 0; m_b = 2; m_idx = 0; m_busy = 0; m_cnt = 0;
        end else begin
            automatic bit frz = m_b[7];
            automatic bit st  = (m_busy != 0) && (m_cnt == LEAD) && !frz;
            if (frz) begin m_busy = 0; m_cnt = 0; end
            else if (m_busy != 0) begin
                if (m_cnt == LEAD + HOLD) m_busy = 0; else m_cnt++;
            end else if (sec_pulse) begin m_busy = 1; m_cnt = 0; end
            if (st) model_advance();
            if (data_we) begin
                if (m_idx < 10) m_t[m_idx] = wdata;
                else if (m_idx == 10) m_a = wdata & 127;
                else if (m_idx == 11) m_b = wdata;
                else if (m_idx >= 14 && m_idx < 64) m_ram[m_idx - 14] = wdata;
            end
            if (idx_we) m_idx = wdata;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // R1/R8 per-cycle: indexed byte (including the update flag) vs model.
    always @(negedge clk) begin
        if (rst_n && !done) chk("R1 per-cycle model", int'(rdata), m_read());
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr_idx(input int i);
        @(negedge clk); idx_we = 1'b1; wdata = 8'(i);
        @(negedge clk); idx_we = 1'b0;
    endtask

    task automatic wr_reg(input int i, input int d);
        wr_idx(i);
        data_we = 1'b1; wdata = 8'(d);
        @(negedge clk); data_we = 1'b0;
    endtask

    task automatic rd_chk(input int i, input int exp, input string tag);
        wr_idx(i);
        chk(tag, int'(rdata), exp);
    endtask

    task automatic one_second();
        @(negedge clk); sec_pulse = 1'b1;
        @(negedge clk); sec_pulse = 1'b0;
        repeat (LEAD + HOLD + 3) @(negedge clk);
    endtask

    task automatic load_time(input int b, input int s, input int mi, input int h,
                             input int dw, input int dm, input int mo, input int yr);
        wr_reg(11, b | 8'h80);
        wr_reg(0, s); wr_reg(2, mi); wr_reg(4, h);
        wr_reg(6, dw); wr_reg(7, dm); wr_reg(8, mo); wr_reg(9, yr);
        wr_reg(11, b);
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        rd_chk(0, 8'h00, "R12 seconds");
        rd_chk(6, 8'h01, "R12 day of week");
        rd_chk(7, 8'h01, "R12 date");
        rd_chk(8, 8'h01, "R12 month");
        rd_chk(11, 8'h02, "R12 control B");
        rd_chk(40, 8'h00, "R12 RAM");

        // R1 alarm bytes: storage only
        wr_reg(5, 8'h42); wr_reg(3, 8'h17);
        one_second();
        rd_chk(5, 8'h42, "R1 alarm hours");
        rd_chk(3, 8'h17, "R1 alarm minutes");

        // R2/R4/R5/R6 BCD 24-hour end of century
        load_time(8'h02, 8'h59, 8'h59, 8'h23, 7, 8'h31, 8'h12, 8'h99);
        one_second();
        rd_chk(0, 8'h00, "R2 seconds wrap");
        rd_chk(2, 8'h00, "R2 minutes wrap");
        rd_chk(4, 8'h00, "R4 24h hour wrap");
        rd_chk(6, 8'h01, "R5 day of week 7->1");
        rd_chk(7, 8'h01, "R5 date wrap");
        rd_chk(8, 8'h01, "R6 month 12->1");
        rd_chk(9, 8'h00, "R6 year 99->0");

        // R2 BCD nibble carry in minutes
        load_time(8'h02, 8'h59, 8'h29, 8'h09, 2, 8'h05, 8'h03, 8'h10);
        one_second();
        rd_chk(2, 8'h30, "R2 BCD minute carry");
        rd_chk(4, 8'h09, "R2 hour held");

        // R4 12-hour forms
        load_time(8'h00, 8'h59, 8'h59, 8'h91, 3, 8'h15, 8'h06, 8'h21);
        one_second();
        rd_chk(4, 8'h12, "R4 11PM->12AM");
        rd_chk(7, 8'h16, "R4 day carry at midnight");
        rd_chk(6, 8'h04, "R5 day of week step");
        load_time(8'h00, 8'h59, 8'h59, 8'h11, 3, 8'h15, 8'h06, 8'h21);
        one_second();
        rd_chk(4, 8'h92, "R4 11AM->12PM");
        rd_chk(7, 8'h15, "R4 no day carry at noon");
        load_time(8'h00, 8'h59, 8'h59, 8'h92, 3, 8'h15, 8'h06, 8'h21);
        one_second();
        rd_chk(4, 8'h81, "R4 12PM->1PM");

        // R3/R5 binary month lengths
        load_time(8'h06, 59, 59, 23, 2, 28, 2, 24);
        one_second();
        rd_chk(7, 29, "R5 leap February 29");
        rd_chk(8, 2, "R5 still February");
        load_time(8'h06, 59, 59, 23, 3, 29, 2, 24);
        one_second();
        rd_chk(7, 1, "R5 leap February end");
        rd_chk(8, 3, "R5 March");
        load_time(8'h06, 59, 59, 23, 3, 28, 2, 23);
        one_second();
        rd_chk(7, 1, "R5 common February end");
        load_time(8'h06, 59, 59, 23, 4, 30, 4, 23);
        one_second();
        rd_chk(8, 5, "R5 April has 30 days");
        load_time(8'h06, 9, 0, 5, 1, 1, 1, 0);
        one_second();
        rd_chk(0, 8'h0A, "R3 binary seconds 9->10");

        // R9 mode change keeps stored bytes
        wr_reg(11, 8'h02);
        rd_chk(0, 8'h0A, "R9 seconds after BCD select");
        wr_reg(11, 8'h00);
        rd_chk(4, 8'h05, "R9 hour after 12h select");
        wr_reg(11, 8'h06);

        // R7 set bit freezes
        wr_reg(11, 8'h86);
        wr_idx(10);
        @(negedge clk); sec_pulse = 1'b1;
        @(negedge clk); sec_pulse = 1'b0;
        chk("R7 no update flag while set", int'(rdata[7]), 0);
        repeat (LEAD + HOLD + 3) @(negedge clk);
        rd_chk(0, 8'h0A, "R7 seconds frozen");
        wr_reg(11, 8'h06);

        // R8 update flag timing and read-only bit
        wr_reg(10, 8'hFF);
        rd_chk(10, 8'h7F, "R8 flag bit read-only");
        @(negedge clk); sec_pulse = 1'b1;
        @(negedge clk); sec_pulse = 1'b0;
        chk("R8 flag rises after strobe", int'(rdata[7]), 1);
        repeat (LEAD + HOLD + 3) @(negedge clk);
        chk("R8 flag clear after window", int'(rdata[7]), 0);
        rd_chk(0, 8'h0B, "R8 one advance per strobe");

        // R10 status bytes
        wr_reg(13, 8'h00);
        rd_chk(13, 8'h80, "R10 status D");
        wr_reg(12, 8'hFF);
        rd_chk(12, 8'h00, "R10 status C");

        // R11 RAM span and misses
        wr_reg(14, 8'hA5); wr_reg(63, 8'h3C); wr_reg(64, 8'h77); wr_reg(255, 8'h11);
        rd_chk(14, 8'hA5, "R11 first RAM byte");
        rd_chk(63, 8'h3C, "R11 last RAM byte");
        rd_chk(64, 8'h00, "R11 beyond RAM reads zero");
        rd_chk(255, 8'h00, "R11 top index reads zero");
        rd_chk(15, 8'h00, "R11 neighbour untouched");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule